// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes an integer quotient or remainder over several clock cycles. It handles signed and unsigned operands. It works either as a full-width unit or as a half-width unit. In full-width mode, a word flag selects a half-width operation whose result is widened to the full register by copying its sign bit. A one-cycle start strobe captures the operands, the operation code and the two flags. Later, a one-cycle done strobe marks the result as valid.

Divisors of zero and the signed overflow case (most-negative value divided by minus one) are detected when the operation is accepted. Their fixed results return after one cycle, without iterating. All other operations go through a restoring radix-2 loop that works on operand magnitudes. A final cycle then applies the signs and the result width.

Top module: `intdiv_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: The operation code is 00 for signed divide, 01 for unsigned divide, 10 for signed remainder and 11 for unsigned remainder. Unsigned results of a full-width operation are the exact quotient and remainder. For a normal (non-special) operation, `done_o` rises in the W+1th cycle after the cycle in which start was accepted, where W is 64 for a full-width operation and 32 for a half-width operation.
- R3: A signed quotient truncates toward zero. A signed remainder takes the sign of the dividend.
- R4: A half-width operation uses bits 31:0 of each operand. It returns a 32-bit result sign-extended from bit 31 to 64 bits, for both signed and unsigned codes. An operation is half-width when `mode64_i` is 0, or when `word_i` is 1.
- R5: For a signed divide by zero, the result is the most-negative value if the dividend is negative, and the most-positive value otherwise. For a half-width operation, these are the 32-bit extremes, sign-extended.
- R6: For a signed divide of the most-negative value by minus one, the result is the most-negative value. The signed remainder of that pair is 0.
- R7: For an unsigned divide by zero, the result is all ones.
- R8: For a remainder by zero, signed or unsigned, the result is the dividend. For a half-width operation, the dividend is sign-extended from bit 31.
- R9: A divide by zero and the signed overflow case raise `done_o` in the cycle after the start cycle.
- R10: `done_o` is high for exactly one cycle per accepted operation. A start raised while an operation is in progress is ignored, and it produces neither a result nor a done.
- R11: When `mode64_i` is 0, `word_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 2 | Operation code (see R2) |
| word_i | input | 1 | Half-width operation in full-width mode |
| mode64_i | input | 1 | 1 = full-width register mode, 0 = half-width mode |
| a_i | input | 64 | Dividend |
| b_i | input | 64 | Divisor |
| result_o | output | 64 | Quotient or remainder, valid while done_o is high |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume the following:
- Operands and flags are known values in the cycle a start is accepted. The unit samples them only in that cycle.
- The divisor magnitude register is non-zero whenever the loop iterates, because zero divisors leave through the special path.

The bench holds every input steady outside its start cycle. It issues a new operation only once the previous result has been collected, except for one deliberate burst of starts during a long operation. That burst includes divide-by-zero starts that would complete at once if they were accepted.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
    parameter int XLEN = 64;
    localparam int HLEN = XLEN / 2;
    localparam int CNTW = $clog2(XLEN + 1);

    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX
    } div_st_e;

    typedef struct packed {
        logic neg_q;
        logic neg_r;
        logic want_rem;
        logic narrow;
    } div_ctl_t;

    // widen the lower half by copying its top bit
    function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
        return {{HLEN{v[HLEN-1]}}, v[HLEN-1:0]};
    endfunction

    // operand as seen by the active width and signedness
    function automatic logic [XLEN-1:0] fit_operand(input logic [XLEN-1:0] v,
                                                    input logic narrow,
                                                    input logic sgn);
        if (!narrow) return v;
        if (sgn)     return sext_half(v);
        return {{HLEN{1'b0}}, v[HLEN-1:0]};
    endfunction
endpackage

// File: rtl/intdiv_special.sv
module intdiv_special
    import intdiv_pkg::*;
(
    input  div_op_e         op,
    input  logic            narrow,
    input  logic [XLEN-1:0] a_ext,
    input  logic [XLEN-1:0] b_ext,
    output logic            hit,
    output logic [XLEN-1:0] value
);
    logic            is_signed, is_rem, b_zero, s_ovf;
    logic [XLEN-1:0] min_v, max_v, a_res;

    assign is_signed = ~op[0];
    assign is_rem    = op[1];
    assign min_v     = narrow ? {{(HLEN+1){1'b1}}, {(HLEN-1){1'b0}}}
                              : {1'b1, {(XLEN-1){1'b0}}};
    assign max_v     = ~min_v;
    assign b_zero    = (b_ext == '0);
    assign s_ovf     = is_signed && (a_ext == min_v) && (b_ext == '1);
    assign a_res     = narrow ? sext_half(a_ext) : a_ext;

    always_comb begin
        hit   = 1'b0;
        value = '0;
        if (b_zero) begin
            hit = 1'b1;
            if (is_rem)         value = a_res;
            else if (is_signed) value = a_ext[XLEN-1] ? min_v : max_v;
            else                value = '1;
        end else if (s_ovf) begin
            hit   = 1'b1;
            value = is_rem ? '0 : min_v;
        end
    end
endmodule

// File: rtl/intdiv_core.sv
module intdiv_core
    import intdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            narrow_i,
    input  logic [XLEN-1:0] dvd_mag_i,
    input  logic [XLEN-1:0] dsr_mag_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    logic [XLEN:0]   acc_q;
    logic [XLEN-1:0] quo_q, dsr_q;
    logic [XLEN:0]   shifted, diff;

    assign shifted = {acc_q[XLEN-1:0], quo_q[XLEN-1]};
    assign diff    = shifted - {1'b0, dsr_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            quo_q <= narrow_i ? (dvd_mag_i << HLEN) : dvd_mag_i;
            dsr_q <= dsr_mag_i;
        end else if (step_i) begin
            if (!diff[XLEN]) begin
                acc_q <= diff;
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                acc_q <= shifted;
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = acc_q[XLEN-1:0];

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (acc_q < {1'b0, dsr_q})); // R2
endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic            mode64_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] result_o,
    output logic            done_o
);
    div_st_e         state_q;
    logic [CNTW-1:0] cnt_q;
    div_ctl_t        ctl_q;

    div_op_e         op;
    logic            narrow, is_signed, accept, sp_hit;
    logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag, sp_val;
    logic [XLEN-1:0] quo, rem, q_s, r_s, pick, fix_val;

    assign op        = div_op_e'(op_i);
    assign narrow    = ~mode64_i | word_i;
    assign is_signed = ~op_i[0];
    assign accept    = start_i && (state_q == ST_IDLE);
    assign a_ext     = fit_operand(a_i, narrow, is_signed);
    assign b_ext     = fit_operand(b_i, narrow, is_signed);
    assign a_mag     = (is_signed && a_ext[XLEN-1]) ? -a_ext : a_ext;
    assign b_mag     = (is_signed && b_ext[XLEN-1]) ? -b_ext : b_ext;

    intdiv_special u_special (
        .op     (op),
        .narrow (narrow),
        .a_ext  (a_ext),
        .b_ext  (b_ext),
        .hit    (sp_hit),
        .value  (sp_val)
    );

    intdiv_core u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept && !sp_hit),
        .step_i    (state_q == ST_RUN),
        .narrow_i  (narrow),
        .dvd_mag_i (a_mag),
        .dsr_mag_i (b_mag),
        .quo_o     (quo),
        .rem_o     (rem)
    );

    assign q_s     = ctl_q.neg_q ? -quo : quo;
    assign r_s     = ctl_q.neg_r ? -rem : rem;
    assign pick    = ctl_q.want_rem ? r_s : q_s;
    assign fix_val = ctl_q.narrow ? sext_half(pick) : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            ctl_q    <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (sp_hit) begin
                            result_o <= sp_val;
                            done_o   <= 1'b1;
                        end else begin
                            state_q        <= ST_RUN;
                            cnt_q          <= narrow ? CNTW'(HLEN) : CNTW'(XLEN);
                            ctl_q.neg_q    <= is_signed && (a_ext[XLEN-1] ^ b_ext[XLEN-1]);
                            ctl_q.neg_r    <= is_signed && a_ext[XLEN-1];
                            ctl_q.want_rem <= op_i[1];
                            ctl_q.narrow   <= narrow;
                        end
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNTW'(1)) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    result_o <= fix_val;
                    done_o   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
    AST_QUIET_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> !done_o); // R10
    AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept && sp_hit) |=> done_o); // R9
    AST_DIVU_ZERO: assert property (@(posedge clk) disable iff (rst)
        (accept && op_i == OP_DIVU && b_i == '0) |=> (result_o == '1)); // R7
    AST_REM_ZERO_WIDE: assert property (@(posedge clk) disable iff (rst)
        (accept && op_i[1] && mode64_i && !word_i && b_i == '0)
        |=> (result_o == $past(a_i))); // R8
    AST_SOVF_REM: assert property (@(posedge clk) disable iff (rst)
        (accept && op_i == OP_REM && mode64_i && !word_i &&
         a_i == {1'b1, {(XLEN-1){1'b0}}} && b_i == '1) |=> (result_o == '0)); // R6
endmodule

// File: tb/intdiv_unit_bench.sv
module intdiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        word_i = 1'b0;
    logic        mode64_i = 1'b1;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [63:0] result_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit summary_done = 0;

    typedef struct {
        logic [63:0] exp;
        int          due;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    intdiv_unit u_intdiv_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .word_i(word_i),
        .mode64_i(mode64_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .done_o(done_o)
    );

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // reference from the requirements: value and whether it is a special case
    function automatic logic [64:0] model(input logic [1:0] op, input logic word,
                                          input logic m64, input logic [63:0] a,
                                          input logic [63:0] b);
        logic narrow = !m64 || word;
        logic sgn = !op[1-1];
        logic isrem = op[1];
        longint as, bs, rs;
        logic [63:0] au, bu, r, minv, maxv;
        as = narrow ? longint'(sx(a[31:0])) : longint'(a);
        bs = narrow ? longint'(sx(b[31:0])) : longint'(b);
        au = narrow ? {32'b0, a[31:0]} : a;
        bu = narrow ? {32'b0, b[31:0]} : b;
        minv = narrow ? 64'hFFFF_FFFF_8000_0000 : 64'h8000_0000_0000_0000;
        maxv = narrow ? 64'h0000_0000_7FFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
        if (bu == 0) begin
            if (isrem)    return {1'b1, narrow ? sx(a[31:0]) : a};       // R8
            else if (sgn) return {1'b1, (as < 0) ? minv : maxv};         // R5
            else          return {1'b1, 64'hFFFF_FFFF_FFFF_FFFF};        // R7
        end
        if (sgn && as == longint'(minv) && bs == -1)
            return {1'b1, isrem ? 64'h0 : minv};                         // R6
        if (sgn) begin
            rs = isrem ? (as % bs) : (as / bs);
            r  = 64'(rs);
        end else begin
            r = isrem ? (au % bu) : (au / bu);
        end
        return {1'b0, narrow ? sx(r[31:0]) : r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic word, input logic m64,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [64:0] m;
        item_t it;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        m = model(op, word, m64, a, b);
        it.exp = m[63:0];
        it.tag = tag;
        // R2/R9 latency: special one cycle after accept, else W+1 more
        it.due = m[64] ? cyc + 1 : cyc + (((!m64) || word) ? 34 : 66);
        sb.push_back(it);
        op_i = op; word_i = word; mode64_i = m64; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(0, "R10 unexpected done", result_o, 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(result_o == it.exp, it.tag, result_o, it.exp);
                check(cyc == it.due, {it.tag, " latency R2 R9"}, 64'(cyc), 64'(it.due));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done", 64'(done_o), 64'h0);
        check(result_o == 64'h0, "R1 result", result_o, 64'h0);

        // R2 unsigned full width
        issue(2'b01, 0, 1, 64'd100, 64'd7, "R2 divu");
        issue(2'b11, 0, 1, 64'd100, 64'd7, "R2 remu");
        issue(2'b01, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R2 divu big");
        issue(2'b11, 0, 1, 64'hF000_0000_0000_0001, 64'h1_0000_0000, "R2 remu big");
        // R3 signed truncation and remainder sign
        issue(2'b00, 0, 1, -64'sd7, 64'd2, "R3 div neg/pos");
        issue(2'b10, 0, 1, -64'sd7, 64'd2, "R3 rem neg/pos");
        issue(2'b00, 0, 1, 64'd7, -64'sd2, "R3 div pos/neg");
        issue(2'b10, 0, 1, 64'd7, -64'sd2, "R3 rem pos/neg");
        issue(2'b00, 0, 1, -64'sd7, -64'sd2, "R3 div neg/neg");
        issue(2'b10, 0, 1, 64'h8000_0000_0000_0000, 64'd3, "R3 rem min/3");
        // R4 half-width and word forms, upper operand bits ignored
        issue(2'b00, 0, 0, 64'hABCD_0000_FFFF_FFF9, 64'h1234_0000_0000_0002, "R4 div narrow");
        issue(2'b01, 0, 0, 64'h5555_5555_8000_0000, 64'd1, "R4 divu narrow sext");
        issue(2'b01, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd2, "R4 divuw");
        issue(2'b10, 1, 1, 64'h0000_0001_FFFF_FFF5, 64'd4, "R4 remw");
        // R11 word flag has no effect in half-width mode
        issue(2'b00, 1, 0, 64'hABCD_0000_FFFF_FFF9, 64'h1234_0000_0000_0002, "R11 word in narrow");
        // R5
        issue(2'b00, 0, 1, 64'd5, 64'd0, "R5 div0 pos");
        issue(2'b00, 0, 1, -64'sd5, 64'd0, "R5 div0 neg");
        issue(2'b00, 0, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000, "R5 div0 narrow neg");
        issue(2'b00, 1, 1, 64'h0000_0000_0000_0009, 64'd0, "R5 div0 word pos");
        // R6
        issue(2'b00, 0, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6 div ovf");
        issue(2'b10, 0, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6 rem ovf");
        issue(2'b00, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R6 div ovf narrow");
        // R7
        issue(2'b01, 0, 1, 64'd77, 64'd0, "R7 divu0");
        issue(2'b01, 0, 0, 64'd77, 64'hFFFF_0000_0000_0000, "R7 divu0 narrow");
        // R8
        issue(2'b10, 0, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, "R8 rem0");
        issue(2'b11, 0, 1, 64'hFEDC_BA98_7654_3210, 64'd0, "R8 remu0");
        issue(2'b11, 1, 1, 64'h0000_0000_9000_0001, 64'd0, "R8 remuw0 sext");

        // R10: starts during a running operation are ignored
        issue(2'b01, 0, 1, 64'd1000, 64'd10, "R10 busy base");
        for (int i = 0; i < 3; i++) begin
            op_i = 2'b10; word_i = 0; mode64_i = 1; a_i = 64'd55; b_i = 64'd0;
            start_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        issue(2'b00, 0, 1, 64'd1, 64'd1, "R10 after busy");

        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule